// File: doc/BRIEF.md
# Control-Bit Composed Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit with two data operands. It has no opcode decoder. Each operand passes through two conditioning steps, each selected by its own control bit: a force-to-zero step, then a bitwise invert step. The two conditioned operands then meet in a core stage that either adds them or ANDs them. A last bit can invert the core result.

The six control bits compose into eighteen useful functions: the constants 0, 1 and -1, both operands passed through, their complements and negations, increments and decrements, the sum, both differences, AND and OR. A status pair reports whether the result is zero and whether it is negative.

The block is meant to sit in a small processor datapath. There, the control bits come straight from an instruction field, and the status pair feeds the branch condition logic.

Top module: `ctrl_alu`

## Requirements
- R1: When `clr_a` is 1, the first operand is replaced by all zeros before the invert step; `clr_b` does the same for the second operand.
- R2: When `inv_a` is 1, the first operand, after the zero step, is inverted bitwise; `inv_b` does the same for the second operand.
- R3: When `add_sel` is 1, the core result is the two's-complement sum of the conditioned operands. The sum wraps modulo 2^WIDTH, and no carry or overflow indication exists.
- R4: When `add_sel` is 0, the core result is the bitwise AND of the conditioned operands.
- R5: When `inv_out` is 1, `result` is the bitwise inverse of the core result; when it is 0, `result` equals the core result.
- R6: `is_zero` is 1 exactly when every bit of `result` is 0.
- R7: `is_neg` equals the most significant bit of `result`, which is bit 15 at the default width.
- R8: The control word {clr_a, inv_a, clr_b, inv_b, add_sel, inv_out}, written most significant bit first, gives these functions:
  - 101010 gives 0; 111111 gives 1; 111010 gives -1.
  - 001100 gives a; 110000 gives b.
  - 001101 gives ~a; 110001 gives ~b.
  - 001111 gives -a; 110011 gives -b.
  - 011111 gives a+1; 110111 gives b+1.
  - 001110 gives a-1; 110010 gives b-1.
  - 000010 gives a+b; 010011 gives a-b; 000111 gives b-a.
  - 000000 gives a AND b; 010101 gives a OR b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First data operand |
| b_in | input | WIDTH | Second data operand |
| clr_a | input | 1 | Force first operand to zero |
| inv_a | input | 1 | Invert first operand after the zero step |
| clr_b | input | 1 | Force second operand to zero |
| inv_b | input | 1 | Invert second operand after the zero step |
| add_sel | input | 1 | 1 selects addition, 0 selects bitwise AND |
| inv_out | input | 1 | Invert the core result |
| result | output | WIDTH | Function result |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Most significant bit of the result |

## Verification
The bench builds the block at the default WIDTH of 16. At that width the sign bit sits at bit 15 and the wrap boundaries are 0x7FFF, 0x8000 and 0xFFFF. This puts wrapping sums, and increments and decrements that cross the sign bit, within reach.

Each of the eighteen control words runs against several operand pairs: zero, equal operands, extreme values and mixed bit patterns. The expected values are computed directly from arithmetic on the operands. Equal operands under both subtraction orders drive the zero flag high from a nonzero input.

// File: rtl/alu_pkg.sv
// Package: shared types for the control-bit composed ALU.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package alu_pkg;

    localparam int DEFAULT_WIDTH = 16;

    // Per-operand conditioning controls: zero step first, then invert step.
    typedef struct packed {
        logic clear;
        logic flip;
    } prep_ctl_t;

endpackage

// File: rtl/operand_prep.sv
// Module: operand_prep
// Conditions one operand. The input is first forced to zero when ctl.clear
// is set, and the outcome is then inverted bitwise when ctl.flip is set.
// Assumes the controls are stable while the output is used (combinational).
module operand_prep
    import alu_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  prep_ctl_t        ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // One cell per bit: gate with the clear control, then XOR with the flip control.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic gated;
        assign gated   = din[i] & ~ctl.clear;
        assign dout[i] = gated ^ ctl.flip;
    end

    // Check the fixed outcomes of the clear step.
    always_comb begin
        if (ctl.clear && !ctl.flip)
            AST_CLEAR_ZERO: assert (dout == '0);   // R1
        if (ctl.clear && ctl.flip)
            AST_CLEAR_FLIP_ONES: assert (&dout);   // R2
    end

endmodule

// File: rtl/core_combine.sv
// Module: core_combine
// Combines the two conditioned operands. It adds them, wrapping modulo
// 2^WIDTH, when add_sel is set, and ANDs them bitwise otherwise.
// Assumes no carry-out is needed downstream.
module core_combine #(
    parameter int WIDTH = alu_pkg::DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             add_sel,
    output logic [WIDTH-1:0] core
);

    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] and_w;

    // Compute both candidate results in parallel.
    always_comb begin
        sum_w = op_a + op_b;
        and_w = op_a & op_b;
    end

    // Choose the core result.
    assign core = add_sel ? sum_w : and_w;

    // In AND mode no result bit may exceed either operand.
    always_comb begin
        if (!add_sel)
            AST_AND_SUBSET: assert ((core & ~op_a) == '0 && (core & ~op_b) == '0);   // R4
        if (add_sel && op_b == '0)
            AST_ADD_IDENTITY: assert (core == op_a);   // R3
    end

endmodule

// File: rtl/result_stage.sv
// Module: result_stage
// Applies the optional output inversion and derives the zero and sign flags.
// Assumes a two's-complement reading of the result for the sign flag.
module result_stage #(
    parameter int WIDTH = alu_pkg::DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] core,
    input  logic             inv_out,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             is_neg
);

    localparam int MSB = WIDTH - 1;

    // Invert the core result on request.
    assign result = inv_out ? ~core : core;

    // Derive the status flags from the final result.
    always_comb begin
        is_zero = (result == '0);
        is_neg  = result[MSB];
    end

    // The output inversion must relate the result to the core result.
    always_comb begin
        if (inv_out)
            AST_OUT_INVERTED: assert ((result ^ core) == '1);   // R5
        else
            AST_OUT_PASSED: assert ((result ^ core) == '0);   // R5
    end

endmodule

// File: rtl/ctrl_alu.sv
// Module: ctrl_alu (top)
// A combinational ALU whose function is set by six independent control bits
// through a fixed chain: zero, invert, add-or-AND, invert-output.
// Assumes the inputs are held stable for as long as the outputs are used.
// There is no clock and no state.
module ctrl_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             clr_a,
    input  logic             inv_a,
    input  logic             clr_b,
    input  logic             inv_b,
    input  logic             add_sel,
    input  logic             inv_out,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             is_neg
);

    localparam int MSB = WIDTH - 1;

    prep_ctl_t        ctl_a;
    prep_ctl_t        ctl_b;
    logic [WIDTH-1:0] cond_a;
    logic [WIDTH-1:0] cond_b;
    logic [WIDTH-1:0] core;

    // Group the per-operand controls.
    always_comb begin
        ctl_a = '{clear: clr_a, flip: inv_a};
        ctl_b = '{clear: clr_b, flip: inv_b};
    end

    operand_prep #(.WIDTH(WIDTH)) u_prep_a (
        .ctl  (ctl_a),
        .din  (a_in),
        .dout (cond_a)
    );

    operand_prep #(.WIDTH(WIDTH)) u_prep_b (
        .ctl  (ctl_b),
        .din  (b_in),
        .dout (cond_b)
    );

    core_combine #(.WIDTH(WIDTH)) u_core (
        .op_a    (cond_a),
        .op_b    (cond_b),
        .add_sel (add_sel),
        .core    (core)
    );

    result_stage #(.WIDTH(WIDTH)) u_out (
        .core    (core),
        .inv_out (inv_out),
        .result  (result),
        .is_zero (is_zero),
        .is_neg  (is_neg)
    );

    // Cross-check the flags against the result port driven by another stage.
    always_comb begin
        AST_SIGN_FLAG: assert (is_neg == result[MSB]);   // R7
        AST_ZERO_FLAG: assert (is_zero == (result == '0));   // R6
    end

endmodule

// File: tb/tb_ctrl_alu.sv
// Bench for ctrl_alu: a driver task applies stimulus and queues expected items,
// and a monitor process pops the items and compares them with the outputs.
module tb_ctrl_alu;

    localparam int W        = 16;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 20000;

    typedef struct {
        logic [W-1:0] exp_res;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         clr_a = 1'b0, inv_a = 1'b0, clr_b = 1'b0, inv_b = 1'b0;
    logic         add_sel = 1'b0, inv_out = 1'b0;
    logic [W-1:0] result;
    logic         is_zero, is_neg;

    item_t queue_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;

    ctrl_alu #(.WIDTH(W)) dut (
        .a_in, .b_in, .clr_a, .inv_a, .clr_b, .inv_b,
        .add_sel, .inv_out, .result, .is_zero, .is_neg
    );

    always #(CLK_PER/2) clk = ~clk;

    // Driver: apply one control word and operand pair, and queue the expected result.
    task automatic drive(input logic [5:0] cw, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] exp_r,
                         input string tag);
        @(posedge clk);
        #1;
        {clr_a, inv_a, clr_b, inv_b, add_sel, inv_out} = cw;
        a_in = a;
        b_in = b;
        queue_q.push_back('{exp_res: exp_r, tag: tag});
    endtask

    // Monitor: compare the result and both flags half a period after each drive.
    always @(negedge clk) begin
        if (rst_n && queue_q.size() > 0) begin
            item_t it;
            it = queue_q.pop_front();
            n_checks++;
            if (result !== it.exp_res) begin
                n_fails++;
                $display("FAIL %s result: actual %h expected %h", it.tag, result, it.exp_res);
            end
            n_checks++;
            if (is_zero !== (it.exp_res == '0)) begin
                n_fails++;
                $display("FAIL R6 zero flag (%s): actual %b expected %b",
                         it.tag, is_zero, it.exp_res == '0);
            end
            n_checks++;
            if (is_neg !== it.exp_res[W-1]) begin
                n_fails++;
                $display("FAIL R7 sign flag (%s): actual %b expected %b",
                         it.tag, is_neg, it.exp_res[W-1]);
            end
        end
    end

    // Run all eighteen functions against one operand pair (R8).
    task automatic run_table(input logic [W-1:0] a, input logic [W-1:0] b);
        drive(6'b101010, a, b, '0,            "R8 zero");
        drive(6'b111111, a, b, W'(1),         "R8 one");
        drive(6'b111010, a, b, '1,            "R8 minus one");
        drive(6'b001100, a, b, a,             "R8 pass a");
        drive(6'b110000, a, b, b,             "R8 pass b");
        drive(6'b001101, a, b, ~a,            "R8 not a / R2");
        drive(6'b110001, a, b, ~b,            "R8 not b / R2");
        drive(6'b001111, a, b, W'(-a),        "R8 neg a");
        drive(6'b110011, a, b, W'(-b),        "R8 neg b");
        drive(6'b011111, a, b, W'(a + 1),     "R8 a plus one / R3");
        drive(6'b110111, a, b, W'(b + 1),     "R8 b plus one / R3");
        drive(6'b001110, a, b, W'(a - 1),     "R8 a minus one");
        drive(6'b110010, a, b, W'(b - 1),     "R8 b minus one");
        drive(6'b000010, a, b, W'(a + b),     "R8 sum / R3");
        drive(6'b010011, a, b, W'(a - b),     "R8 a minus b / R5");
        drive(6'b000111, a, b, W'(b - a),     "R8 b minus a / R5");
        drive(6'b000000, a, b, a & b,         "R8 and / R4");
        drive(6'b010101, a, b, a | b,         "R8 or / R4");
    endtask

    // Main sequence.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: all-zero inputs with AND selected give zero.
        drive(6'b000000, '0, '0, '0, "R4 reset-state all zero");
        // R1: clearing a in sum mode leaves just b; clearing b leaves just a.
        drive(6'b100010, 16'h1234, 16'h0F0F, 16'h0F0F, "R1 clear a in sum");
        drive(6'b001000, 16'h1234, 16'hFFFF, 16'h0000, "R1 clear b in and");
        // R3: the sum wraps with no extra output.
        drive(6'b000010, 16'hFFFF, 16'h0001, 16'h0000, "R3 wrap to zero");
        drive(6'b000010, 16'h7FFF, 16'h0001, 16'h8000, "R3 wrap into sign bit");
        run_table(16'h0000, 16'h0000);
        run_table(16'h1234, 16'h00F0);
        run_table(16'h7FFF, 16'h8000);
        run_table(16'hA5A5, 16'hA5A5);
        run_table(16'hFFFF, 16'h0001);
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule